// File: doc/BRIEF.md
# Clocked Tapped Delay Line with Deferred Tap Update

This block delays a single-bit signal by a programmable number of clock cycles. Each clock it samples the input into a chain of 256 stages. An 8-bit tap selection picks which stage feeds a registered output, so the output is the input, uninverted, shifted by a fixed two-cycle base latency plus one cycle per unit of the selection.

A new selection is requested with a one-cycle strobe and a code. It is not applied at once. It waits until the sampled input has held one level long enough for every stage of the chain to carry that same level. The swap is then invisible at the output, and no stale edge from the old tap leaks out. A small controller with two states does the waiting. In RUN no request is outstanding. A strobe in RUN takes the controller to HOLD. In HOLD the request waits. The controller goes from HOLD back to RUN on the APPLY transition, which happens when the quiet condition holds and no new strobe arrives in that cycle. A strobe in HOLD replaces the waiting code and the controller stays in HOLD.

Top module: `tap_delay_line`

## Requirements
- R1: After synchronous reset, `sig_out` is 0, `tap_sel` is 0 and `upd_pending` is 0. All stages are cleared to 0.
- R2: While `tap_sel` holds a value c, a level driven on `sig_in` before clock edge n appears on `sig_out` after edge n+1+c, uninverted. At the negedge sampling point that is c+2 cycles after it was sampled.
- R3: The two extreme selections give the minimum and maximum delay: code 0 gives 2 cycles and code 255 gives 257 cycles.
- R4: A strobe on `upd_req` raises `upd_pending` after the next edge. `tap_sel` changes only on an edge where `upd_pending` falls.
- R5: If the last change of `sig_in` is sampled at edge E, a waiting code becomes active at edge E+257 at the earliest, and only if no further change is sampled through E+257. Any change while waiting restarts the count.
- R6: A strobe while a request is waiting overwrites the waiting code. Only the most recent code is applied.
- R7: On the APPLY edge `upd_pending` falls and `tap_sel` takes the waiting code. `sig_out` has no edge on that edge or on the next one.
- R8: When the input has already been quiet for at least 257 sampled edges, a strobe at edge n is applied at edge n+1. `upd_pending` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Signal to be delayed |
| upd_req | input | 1 | One-cycle strobe requesting a new tap |
| upd_code | input | 8 | Requested tap selection, sampled with `upd_req` |
| sig_out | output | 1 | Delayed copy of `sig_in` |
| tap_sel | output | 8 | Tap selection currently in force |
| upd_pending | output | 1 | High while a requested code waits to be applied |

## Verification
The hardest condition to reach is the exact edge at which a waiting code takes effect. It depends on counting 257 quiet samples after the last input change, and a change part-way through the wait has to restart that count. The stimulus toggles the input while a request waits. It then makes one final change, holds the level 200 cycles, and makes a further change to force a restart. The check looks at the outputs on the cycle just before the permitted APPLY edge and on the cycle just after it. A separate sequence strobes a request into a line that is already quiet, to reach the earliest APPLY edge.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } upd_state_t;
endpackage

// File: rtl/tdl_shift_chain.sv
module tdl_shift_chain #(
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst) taps[0] <= 1'b0;
        else     taps[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) taps[i] <= 1'b0;
            else     taps[i] <= taps[i-1];
        end
    end
endmodule

// File: rtl/tdl_idle_timer.sv
module tdl_idle_timer #(
    parameter int LIMIT = 256,
    parameter int CNT_W = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic last_sample,
    output logic idle_full
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] quiet_cnt;
    logic             changed;

    assign changed = din ^ last_sample;

    always_ff @(posedge clk) begin
        if (rst)                  quiet_cnt <= '0;
        else if (changed)         quiet_cnt <= '0;
        else if (quiet_cnt != LIM) quiet_cnt <= quiet_cnt + 1'b1;
    end

    // quiet for the whole chain and still quiet on this edge
    assign idle_full = (quiet_cnt == LIM) && !changed;
endmodule

// File: rtl/tdl_update_ctrl.sv
module tdl_update_ctrl
    import tdl_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CODE_W-1:0] req_code,
    input  logic              idle_full,
    output logic [CODE_W-1:0] code_q,
    output logic              pend_q
);
    upd_state_t        state, nxt;
    logic [CODE_W-1:0] wait_code;
    logic              do_apply;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (req) nxt = ST_HOLD;
            ST_HOLD: if (!req && idle_full) nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    assign do_apply = (state == ST_HOLD) && (nxt == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_code <= '0;
            code_q    <= '0;
            pend_q    <= 1'b0;
        end else begin
            if (req)      wait_code <= req_code;
            if (do_apply) code_q    <= wait_code;
            pend_q <= (nxt == ST_HOLD);
        end
    end
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic              upd_req,
    input  logic [CODE_W-1:0] upd_code,
    output logic              sig_out,
    output logic [CODE_W-1:0] tap_sel,
    output logic              upd_pending
);
    localparam int DEPTH = 1 << CODE_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] taps;
    logic             idle_full;

    tdl_shift_chain #(.DEPTH(DEPTH)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (sig_in),
        .taps (taps)
    );

    tdl_idle_timer #(.LIMIT(DEPTH), .CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .din         (sig_in),
        .last_sample (taps[0]),
        .idle_full   (idle_full)
    );

    tdl_update_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (upd_req),
        .req_code  (upd_code),
        .idle_full (idle_full),
        .code_q    (tap_sel),
        .pend_q    (upd_pending)
    );

    always_ff @(posedge clk) begin
        if (rst) sig_out <= 1'b0;
        else     sig_out <= taps[tap_sel];
    end
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sig_in,
    input logic              upd_req,
    input logic [CODE_W-1:0] tap_sel,
    input logic              upd_pending,
    input logic              sig_out
);
    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    assert_zero_code_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(tap_sel) == '0) |-> (sig_out == $past(sig_in, 2)));

    assert_req_sets_pending_R4: assert property (@(posedge clk) disable iff (rst)
        upd_req |=> upd_pending);

    assert_tap_moves_on_apply_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(tap_sel) |-> $fell(upd_pending));

    assert_idle_keeps_tap_R4: assert property (@(posedge clk) disable iff (rst)
        !upd_pending |=> $stable(tap_sel));

    assert_apply_on_quiet_input_R5: assert property (@(posedge clk) disable iff (rst)
        (warm && $fell(upd_pending)) |-> $stable(sig_in));

    assert_no_edge_at_apply_R7: assert property (@(posedge clk) disable iff (rst)
        (warm && $fell(upd_pending)) |-> $stable(sig_out));

    assert_no_edge_after_apply_R7: assert property (@(posedge clk) disable iff (rst)
        (warm && $fell(upd_pending)) |=> $stable(sig_out));
endmodule

bind tap_delay_line tdl_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sig_in      (sig_in),
    .upd_req     (upd_req),
    .tap_sel     (tap_sel),
    .upd_pending (upd_pending),
    .sig_out     (sig_out)
);

// File: tb/sim_tap_delay_line.sv
`timescale 1ns/1ps
module sim_tap_delay_line;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig_in = 1'b0;
    logic       upd_req = 1'b0;
    logic [7:0] upd_code = 8'd0;
    logic       sig_out;
    logic [7:0] tap_sel;
    logic       upd_pending;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic hist [0:511];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    tap_delay_line u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .upd_req(upd_req),
        .upd_code(upd_code), .sig_out(sig_out), .tap_sel(tap_sel),
        .upd_pending(upd_pending)
    );

    // reference queue of sampled inputs
    always @(posedge clk) begin
        hist[cyc & 511] <= sig_in;
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic expect_out(input int code);
        return hist[(cyc - 2 - code) & 511];
    endfunction

    task automatic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[1:0] != 2'b00) sig_in = ~sig_in;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sig_out == 1'b0, "R1 sig_out", sig_out, 0);
        chk(tap_sel == 8'd0, "R1 tap_sel", tap_sel, 0);
        chk(upd_pending == 1'b0, "R1 pending", upd_pending, 0);
    endtask

    // hold input, request code, wait for APPLY, confirm no output edge (R7)
    task automatic t_set_code(input int code);
        int edges = 0;
        int waited = 0;
        logic lvl;
        logic prev;
        repeat (260) @(negedge clk);
        lvl = sig_in;
        chk(sig_out == lvl, "R7 settled level", sig_out, lvl);
        upd_req = 1'b1; upd_code = 8'(code);
        @(negedge clk);
        upd_req = 1'b0;
        prev = sig_out;
        while (upd_pending && waited < 700) begin
            @(negedge clk);
            waited++;
            if (sig_out != prev) edges++;
            prev = sig_out;
        end
        repeat (3) begin
            @(negedge clk);
            if (sig_out != prev) edges++;
            prev = sig_out;
        end
        chk(edges == 0, "R7 no output edge across update", edges, 0);
        chk(tap_sel == 8'(code), "R4 tap applied", tap_sel, code);
    endtask

    task automatic t_delay(input int code, input string req);
        int bad = 0;
        t_set_code(code);
        for (int i = 0; i < code + 80; i++) begin
            @(negedge clk);
            if (sig_out != expect_out(code)) bad++;
            next_bit();
        end
        chk(bad == 0, req, bad, 0);
        chk(upd_pending == 1'b0, "R4 no spurious pending", upd_pending, 0);
    endtask

    task automatic t_defer();
        int bad = 0;
        t_set_code(3);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 10) begin upd_req = 1'b1; upd_code = 8'd9; end
            else upd_req = 1'b0;
            if (i > 11 && (tap_sel != 8'd3 || !upd_pending)) bad++;
            if (sig_out != expect_out(3)) bad++;
            next_bit();
        end
        chk(bad == 0, "R5 old tap kept while input toggles", bad, 0);
        @(negedge clk); sig_in = ~sig_in;
        repeat (200) @(negedge clk);
        chk(upd_pending == 1'b1, "R5 still waiting", upd_pending, 1);
        sig_in = ~sig_in;           // restart the quiet window
        repeat (257) @(negedge clk);
        chk(tap_sel == 8'd3, "R5 not applied before E+257", tap_sel, 3);
        chk(upd_pending == 1'b1, "R5 pending before E+257", upd_pending, 1);
        @(negedge clk);
        chk(tap_sel == 8'd9, "R5 applied at E+257", tap_sel, 9);
        chk(upd_pending == 1'b0, "R7 pending falls with apply", upd_pending, 0);
    endtask

    task automatic t_fast();
        repeat (5) @(negedge clk);
        upd_req = 1'b1; upd_code = 8'd200;
        @(negedge clk);
        upd_req = 1'b0;
        chk(upd_pending == 1'b1, "R8 pending after strobe", upd_pending, 1);
        chk(tap_sel == 8'd9, "R8 old tap one cycle", tap_sel, 9);
        @(negedge clk);
        chk(upd_pending == 1'b0, "R8 pending one cycle", upd_pending, 0);
        chk(tap_sel == 8'd200, "R8 applied next edge", tap_sel, 200);
    endtask

    task automatic t_overwrite();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            upd_req = (i == 5 || i == 20);
            upd_code = (i == 5) ? 8'd50 : 8'd77;
            next_bit();
        end
        @(negedge clk); upd_req = 1'b0;
        for (int i = 0; i < 700 && upd_pending; i++) @(negedge clk);
        chk(tap_sel == 8'd77, "R6 latest code wins", tap_sel, 77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_delay(0,   "R3 code 0 delay");
        t_delay(1,   "R2 code 1 delay");
        t_delay(2,   "R2 code 2 delay");
        t_delay(37,  "R2 code 37 delay");
        t_delay(128, "R2 code 128 delay");
        t_delay(254, "R2 code 254 delay");
        t_delay(255, "R3 code 255 delay");
        t_defer();
        t_fast();
        t_overwrite();
        t_delay(6,   "R2 code 6 after overwrite");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule